// File: doc/BRIEF.md
# UART Interrupt Cause Encoder

This block sits beside a UART's FIFOs and serial engine and turns their status into one interrupt line plus a cause byte that the CPU reads to decide which service routine to run. It watches the receive and transmit FIFO fill levels, the transmit shift register state, a line-error level, a receive-timeout strobe, a modem-change level, and two strobes for an XOFF character seen and a flow-control state change. Three small configuration registers shape its behaviour. The enable register masks individual causes. The FIFO control register turns the FIFOs on, issues clear pulses, selects the DMA mode and picks the receive and transmit trigger depths. The supplementary control register can hold off the transmit interrupt until the transmitter has fully drained.

Only the most urgent enabled cause is reported at any time. The least significant bit of the cause byte is low while something is pending. Software clears a cause by removing its condition (draining the receive FIFO, refilling the transmit FIFO) or, for the latched causes, by reading the cause byte while that cause is shown. The FIFO storage, the shift engine and the character-time counter live elsewhere and appear here only as levels and strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is high, and on the first edge out of it, `id_byte` is 0x01, `irq` is 0, both clear pulses are 0 and `dma_sel` is 0.
- R2: `id_byte[0]` is 0 and `irq` is 1 while a cause is pending. With nothing pending, `id_byte[5:0]` is 0x01 and `irq` is 0.
- R3: `id_byte[7:6]` both equal the FIFO-enable bit, which is bit 0 of the FIFO control register. The value is 0xC0 in those bits with FIFOs on.
- R4: One cause is shown at a time, as `id_byte[5:0]`, in this priority from highest: line error 0x06, receive timeout 0x0C, receive data 0x04, transmit space 0x02, modem change 0x00, XOFF seen 0x10, flow change 0x20.
- R5: Receive data is enabled by enable bit 0. With FIFOs on it is raised while `rx_level` is at or above the trigger chosen by FIFO control bits 7:6: code 0 = 8, 1 = 16, 2 = 56, 3 = 60 characters. With FIFOs off the trigger is 1. It drops once the level falls below the trigger.
- R6: Transmit space is enabled by enable bit 1. With FIFOs on its condition is that the free space `DEPTH - tx_level` is at least the trigger chosen by FIFO control bits 5:4: code 0 = 8, 1 = 16, 2 = 32, 3 = 56. With FIFOs off the condition is `tx_level == 0`.
- R7: When supplementary control bit 0 is set, the transmit condition is instead `tx_level == 0` and `tx_shift_empty == 1`.
- R8: A transmit cause is acknowledged by a `id_rd` pulse while 0x02 is shown, or by a `thr_we` pulse. It returns only after its condition has gone false and true again, or after enable bit 1 goes from 0 to 1.
- R9: A receive timeout is latched from the `rx_tmo` strobe and gated by enable bit 0. It is cleared by a `id_rd` pulse while 0x0C is shown, or when `rx_level` is 0. A new strobe takes precedence over a clear in the same cycle.
- R10: Line error (enable bit 2) and modem change (enable bit 3) follow their input levels. XOFF seen (enable bit 5) and flow change (enable bit 7) are latched from their strobes and cleared by a `id_rd` pulse while their code is shown.
- R11: `cfg_sel` 0 selects the enable register, 1 the FIFO control register, 2 the supplementary control register, and 3 is ignored. Writing FIFO control with bit 1 or bit 2 set gives a one-cycle pulse on `rx_fifo_clr` or `tx_fifo_clr`. Bit 3 drives `dma_sel`.
- R12: Every output reflects the inputs and writes sampled at the same clock edge that updates it, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 FIFO control, 2 supplementary control |
| cfg_wdata | input | 8 | Configuration write data |
| id_rd | input | 1 | Pulse: CPU read of the cause byte |
| thr_we | input | 1 | Pulse: CPU wrote a character for transmission |
| rx_level | input | LW | Receive FIFO fill count, LW = clog2(DEPTH+1) |
| tx_level | input | LW | Transmit FIFO fill count |
| tx_shift_empty | input | 1 | Transmit shift register idle |
| line_err | input | 1 | Receive line error present (level) |
| rx_tmo | input | 1 | Receive character timeout strobe |
| modem_chg | input | 1 | Modem status change present (level) |
| xoff_det | input | 1 | XOFF character detected strobe |
| flow_chg | input | 1 | Flow-control state change strobe |
| irq | output | 1 | Interrupt request, active high |
| id_byte | output | 8 | Cause byte: FIFO mirror, cause code, pending-low bit |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| dma_sel | output | 1 | DMA mode select |

## Verification
Every output is registered and is computed from the values at the edge that loads it. So a level change, a strobe, a configuration write or a cause-byte read driven just after one falling edge is visible at the next falling edge, exactly one cycle later. The bench drives all inputs right after a falling edge. A behavioural model updates at each rising edge from the same inputs, and every output is compared with the model on each falling edge. The directed checks also sample on the falling edge that follows the stimulus edge. The acknowledge cases are covered this way: a read arriving while a code is shown, and a strobe coinciding with a clear.

// File: rtl/uifl_pkg.sv
package uifl_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_FIFO   = 2'd1,
    SEL_SUPP   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  localparam int NSRC = 7;

  localparam logic [5:0] CODE_LINE  = 6'h06;
  localparam logic [5:0] CODE_TMO   = 6'h0C;
  localparam logic [5:0] CODE_RXD   = 6'h04;
  localparam logic [5:0] CODE_TX    = 6'h02;
  localparam logic [5:0] CODE_MODEM = 6'h00;
  localparam logic [5:0] CODE_XOFF  = 6'h10;
  localparam logic [5:0] CODE_FLOW  = 6'h20;
  localparam logic [5:0] ID_IDLE    = 6'h01;

  // index 0 is the most urgent cause
  localparam logic [5:0] CODE_TBL [NSRC] = '{
    CODE_LINE, CODE_TMO, CODE_RXD, CODE_TX, CODE_MODEM, CODE_XOFF, CODE_FLOW
  };
endpackage

// File: rtl/uifl_cfg.sv
module uifl_cfg
  import uifl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] ier_q,
  output logic [7:0] ier_n,
  output logic       fe_n,
  output logic [1:0] rxs_n,
  output logic [1:0] txs_n,
  output logic       wait_shift_n,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic       dma
);
  logic       fe_q, wait_q;
  logic [1:0] rxs_q, txs_q;
  logic       wr_fifo;

  assign wr_fifo = we && (sel == SEL_FIFO);

  always_comb begin
    ier_n        = (we && sel == SEL_ENABLE) ? wdata : ier_q;
    fe_n         = wr_fifo ? wdata[0]   : fe_q;
    txs_n        = wr_fifo ? wdata[5:4] : txs_q;
    rxs_n        = wr_fifo ? wdata[7:6] : rxs_q;
    wait_shift_n = (we && sel == SEL_SUPP) ? wdata[0] : wait_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q  <= '0;
      fe_q   <= 1'b0;
      rxs_q  <= '0;
      txs_q  <= '0;
      wait_q <= 1'b0;
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
      dma    <= 1'b0;
    end else begin
      ier_q  <= ier_n;
      fe_q   <= fe_n;
      rxs_q  <= rxs_n;
      txs_q  <= txs_n;
      wait_q <= wait_shift_n;
      rx_clr <= wr_fifo && wdata[1];
      tx_clr <= wr_fifo && wdata[2];
      if (wr_fifo) dma <= wdata[3];
    end
  end
endmodule

// File: rtl/uifl_trig.sv
module uifl_trig #(
  parameter int DEPTH = 64,
  parameter int RX_T0 = 8,
  parameter int RX_T1 = 16,
  parameter int RX_T2 = 56,
  parameter int RX_T3 = 60,
  parameter int TX_T0 = 8,
  parameter int TX_T1 = 16,
  parameter int TX_T2 = 32,
  parameter int TX_T3 = 56,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          fe,
  input  logic [1:0]    rxs,
  input  logic [1:0]    txs,
  input  logic          wait_shift,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          tx_shift_empty,
  output logic          rx_hit,
  output logic          tx_cond
);
  localparam int RX_TBL [4] = '{RX_T0, RX_T1, RX_T2, RX_T3};
  localparam int TX_TBL [4] = '{TX_T0, TX_T1, TX_T2, TX_T3};

  logic [LW:0] rx_thr, tx_thr, space;
  logic        tx_idle;

  always_comb begin
    rx_thr  = (LW+1)'(RX_TBL[rxs]);
    tx_thr  = (LW+1)'(TX_TBL[txs]);
    space   = (LW+1)'(DEPTH) - {1'b0, tx_level};
    tx_idle = (tx_level == '0);
    rx_hit  = fe ? ({1'b0, rx_level} >= rx_thr) : (rx_level != '0);
    if (wait_shift)
      tx_cond = tx_idle && tx_shift_empty;
    else if (fe)
      tx_cond = (space >= tx_thr);
    else
      tx_cond = tx_idle;
  end
endmodule

// File: rtl/uifl_src.sv
module uifl_src (
  input  logic clk,
  input  logic rst,
  input  logic rx_tmo,
  input  logic xoff_det,
  input  logic flow_chg,
  input  logic rx_empty,
  input  logic tx_cond,
  input  logic tx_en_rise,
  input  logic thr_we,
  input  logic rd_tmo,
  input  logic rd_tx,
  input  logic rd_xoff,
  input  logic rd_flow,
  output logic tmo_n,
  output logic xoff_n,
  output logic flow_n,
  output logic ack_n
);
  logic tmo_q, xoff_q, flow_q, ack_q;

  always_comb begin
    tmo_n = tmo_q;
    if (rx_tmo) tmo_n = 1'b1;
    else if (rx_empty || rd_tmo) tmo_n = 1'b0;

    xoff_n = xoff_q;
    if (xoff_det) xoff_n = 1'b1;
    else if (rd_xoff) xoff_n = 1'b0;

    flow_n = flow_q;
    if (flow_chg) flow_n = 1'b1;
    else if (rd_flow) flow_n = 1'b0;

    if (!tx_cond || tx_en_rise) ack_n = 1'b0;
    else ack_n = ack_q || thr_we || rd_tx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q  <= 1'b0;
      xoff_q <= 1'b0;
      flow_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      tmo_q  <= tmo_n;
      xoff_q <= xoff_n;
      flow_q <= flow_n;
      ack_q  <= ack_n;
    end
  end
endmodule

// File: rtl/uifl_prio.sv
module uifl_prio
  import uifl_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic            pend,
  output logic [5:0]      code
);
  always_comb begin
    pend = 1'b0;
    code = ID_IDLE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        pend = 1'b1;
        code = CODE_TBL[i];
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uifl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  input  logic          id_rd,
  input  logic          thr_we,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          tx_shift_empty,
  input  logic          line_err,
  input  logic          rx_tmo,
  input  logic          modem_chg,
  input  logic          xoff_det,
  input  logic          flow_chg,
  output logic          irq,
  output logic [7:0]    id_byte,
  output logic          rx_fifo_clr,
  output logic          tx_fifo_clr,
  output logic          dma_sel
);
  logic [7:0]      ier_q, ier_n;
  logic            fe_n, wait_n;
  logic [1:0]      rxs_n, txs_n;
  logic            rx_hit, tx_cond;
  logic            tmo_n, xoff_n, flow_n, ack_n;
  logic [NSRC-1:0] req;
  logic            pend;
  logic [5:0]      code;
  logic [5:0]      shown;

  assign shown = id_byte[5:0];

  uifl_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ier_q(ier_q), .ier_n(ier_n), .fe_n(fe_n), .rxs_n(rxs_n), .txs_n(txs_n),
    .wait_shift_n(wait_n), .rx_clr(rx_fifo_clr), .tx_clr(tx_fifo_clr),
    .dma(dma_sel)
  );

  uifl_trig #(.DEPTH(DEPTH)) u_trig (
    .fe(fe_n), .rxs(rxs_n), .txs(txs_n), .wait_shift(wait_n),
    .rx_level(rx_level), .tx_level(tx_level), .tx_shift_empty(tx_shift_empty),
    .rx_hit(rx_hit), .tx_cond(tx_cond)
  );

  uifl_src u_src (
    .clk(clk), .rst(rst), .rx_tmo(rx_tmo), .xoff_det(xoff_det),
    .flow_chg(flow_chg), .rx_empty(rx_level == '0), .tx_cond(tx_cond),
    .tx_en_rise(ier_n[1] && !ier_q[1]), .thr_we(thr_we),
    .rd_tmo(id_rd && shown == CODE_TMO), .rd_tx(id_rd && shown == CODE_TX),
    .rd_xoff(id_rd && shown == CODE_XOFF), .rd_flow(id_rd && shown == CODE_FLOW),
    .tmo_n(tmo_n), .xoff_n(xoff_n), .flow_n(flow_n), .ack_n(ack_n)
  );

  always_comb begin
    req[0] = line_err  && ier_n[2];
    req[1] = tmo_n     && ier_n[0];
    req[2] = rx_hit    && ier_n[0];
    req[3] = tx_cond   && !ack_n && ier_n[1];
    req[4] = modem_chg && ier_n[3];
    req[5] = xoff_n    && ier_n[5];
    req[6] = flow_n    && ier_n[7];
  end

  uifl_prio u_prio (.req(req), .pend(pend), .code(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      id_byte <= {2'b00, ID_IDLE};
    end else begin
      irq     <= pend;
      id_byte <= {fe_n, fe_n, code};
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic [3:0] cfg_wd,
  input logic       id_rd,
  input logic       thr_we,
  input logic       irq,
  input logic [7:0] id_byte,
  input logic       rx_fifo_clr,
  input logic       tx_fifo_clr,
  input logic       dma_sel
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (id_byte == 8'h01 && !irq && !dma_sel)); // R1
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (id_byte[5:0] == 6'h01)); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq |-> (id_byte[5:0] inside {6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20})); // R4
  AST_FIFO_MIRROR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg_we && cfg_sel == 2'd1) |-> (id_byte[7:6] == {2{$past(cfg_wd[0])}})); // R3
  AST_RX_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_clr |-> $past(!rst && cfg_we && cfg_sel == 2'd1 && cfg_wd[1])); // R11
  AST_TX_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_clr |-> $past(!rst && cfg_we && cfg_sel == 2'd1 && cfg_wd[2])); // R11
  AST_DMA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg_we && cfg_sel == 2'd1) |-> (dma_sel == $past(cfg_wd[3]))); // R11
  AST_TX_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && id_rd && id_byte[5:0] == 6'h02 && !(cfg_we && cfg_sel == 2'd0))
      |-> (id_byte[5:0] != 6'h02)); // R8
  AST_TX_WRITE_ACK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && thr_we && !(cfg_we && cfg_sel == 2'd0)) |-> (id_byte[5:0] != 6'h02)); // R8
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wd(cfg_wdata[3:0]), .id_rd(id_rd), .thr_we(thr_we), .irq(irq),
  .id_byte(id_byte), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
  .dma_sel(dma_sel)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          id_rd = 1'b0, thr_we = 1'b0;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic          tx_shift_empty = 1'b1;
  logic          line_err = 1'b0, rx_tmo = 1'b0, modem_chg = 1'b0;
  logic          xoff_det = 1'b0, flow_chg = 1'b0;
  logic          irq, rx_fifo_clr, tx_fifo_clr, dma_sel;
  logic [7:0]    id_byte;

  uart_irq_ident #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .id_rd(id_rd), .thr_we(thr_we),
    .rx_level(rx_level), .tx_level(tx_level), .tx_shift_empty(tx_shift_empty),
    .line_err(line_err), .rx_tmo(rx_tmo), .modem_chg(modem_chg),
    .xoff_det(xoff_det), .flow_chg(flow_chg), .irq(irq), .id_byte(id_byte),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .dma_sel(dma_sel)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int rx_trig_tbl [4] = '{8, 16, 56, 60};
  int tx_trig_tbl [4] = '{8, 16, 32, 56};
  int m_ier, m_fe, m_rxs, m_txs, m_wait, m_dma;
  bit m_tmo, m_xoff, m_flow, m_ack;
  int exp_id = 1, exp_irq = 0, exp_rc = 0, exp_tc = 0, exp_dma = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ier = 0; m_fe = 0; m_rxs = 0; m_txs = 0; m_wait = 0; m_dma = 0;
      m_tmo = 0; m_xoff = 0; m_flow = 0; m_ack = 0;
      exp_id = 1; exp_irq = 0; exp_rc = 0; exp_tc = 0; exp_dma = 0;
    end else begin
      int shown, old_tx_en, thr, code;
      bit rise, rxhit, txc;
      shown = exp_id % 64;
      old_tx_en = (m_ier >> 1) & 1;
      exp_rc = 0; exp_tc = 0;
      if (cfg_we) begin
        if (cfg_sel == 0) m_ier = cfg_wdata;
        else if (cfg_sel == 1) begin
          m_fe = cfg_wdata[0]; m_dma = cfg_wdata[3];
          m_txs = cfg_wdata[5:4]; m_rxs = cfg_wdata[7:6];
          exp_rc = cfg_wdata[1]; exp_tc = cfg_wdata[2];
        end else if (cfg_sel == 2) m_wait = cfg_wdata[0];
      end
      exp_dma = m_dma;
      rise = ((m_ier >> 1) & 1) == 1 && old_tx_en == 0;
      thr = m_fe ? rx_trig_tbl[m_rxs] : 1;
      rxhit = (int'(rx_level) >= thr);
      if (m_wait) txc = (tx_level == 0) && tx_shift_empty;
      else if (m_fe) txc = (DEPTH - int'(tx_level)) >= tx_trig_tbl[m_txs];
      else txc = (tx_level == 0);
      if (!txc || rise) m_ack = 0;
      else if (thr_we || (id_rd && shown == 'h02)) m_ack = 1;
      if (rx_tmo) m_tmo = 1;
      else if (rx_level == 0 || (id_rd && shown == 'h0C)) m_tmo = 0;
      if (xoff_det) m_xoff = 1;
      else if (id_rd && shown == 'h10) m_xoff = 0;
      if (flow_chg) m_flow = 1;
      else if (id_rd && shown == 'h20) m_flow = 0;
      code = -1;
      if (line_err && m_ier[2]) code = 'h06;
      else if (m_tmo && m_ier[0]) code = 'h0C;
      else if (rxhit && m_ier[0]) code = 'h04;
      else if (txc && !m_ack && m_ier[1]) code = 'h02;
      else if (modem_chg && m_ier[3]) code = 'h00;
      else if (m_xoff && m_ier[5]) code = 'h10;
      else if (m_flow && m_ier[7]) code = 'h20;
      exp_irq = (code >= 0);
      exp_id = (m_fe ? 'hC0 : 0) + (exp_irq ? code : 1);
    end
    started = 1;
  end

  function automatic string tag_of(int c);
    case (c % 64)
      'h06, 'h00, 'h10, 'h20: return "R10";
      'h0C: return "R9";
      'h04: return "R5";
      'h02: return "R6";
      default: return "R2";
    endcase
  endfunction

  // every-cycle comparison (R12: one-cycle latency)
  always @(negedge clk) begin
    if (started && !done) begin
      chk({tag_of(exp_id), "/R12 id_byte"}, id_byte, exp_id);
      chk("R2 irq", irq, exp_irq);
      chk("R11 rx_fifo_clr", rx_fifo_clr, exp_rc);
      chk("R11 tx_fifo_clr", tx_fifo_clr, exp_tc);
      chk("R11 dma_sel", dma_sel, exp_dma);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic rd();
    id_rd = 1; tick(); id_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset id", id_byte, 'h01);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset dma", dma_sel, 0);

    wr(1, 8'hF7);
    chk("R11 rx clear pulse", rx_fifo_clr, 1);
    chk("R11 tx clear pulse", tx_fifo_clr, 1);
    chk("R3 mirror on", id_byte, 'hC1);
    tick();
    chk("R11 pulse one cycle", rx_fifo_clr, 0);

    wr(0, 8'h01);
    rx_level = 59; tick(); chk("R5 below 60", id_byte, 'hC1);
    rx_level = 60; tick(); chk("R5 at 60", id_byte, 'hC4);
    chk("R2 irq high", irq, 1);
    rx_level = 59; tick(); chk("R5 falls below", id_byte, 'hC1);

    wr(0, 8'h02);
    chk("R6 empty fifo", id_byte, 'hC2);
    tx_level = 9; tick(); chk("R6 55 spaces", id_byte, 'hC1);
    tx_level = 8; tick(); chk("R6 56 spaces", id_byte, 'hC2);
    rd(); chk("R8 read ack", id_byte, 'hC1);
    tx_level = 9; tick(); tx_level = 8; tick();
    chk("R8 rearm on condition", id_byte, 'hC2);
    thr_we = 1; tick(); thr_we = 0;
    chk("R8 write ack", id_byte, 'hC1);
    wr(0, 8'h00); wr(0, 8'h02);
    chk("R8 rearm on enable", id_byte, 'hC2);

    wr(2, 8'h01);
    tx_level = 0; tx_shift_empty = 0; tick();
    chk("R7 shift busy", id_byte, 'hC1);
    tx_shift_empty = 1; tick();
    chk("R7 fully drained", id_byte, 'hC2);
    wr(2, 8'h00);

    wr(0, 8'hAF);
    line_err = 1; rx_level = 60; modem_chg = 1;
    rx_tmo = 1; xoff_det = 1; flow_chg = 1; tick();
    rx_tmo = 0; xoff_det = 0; flow_chg = 0;
    chk("R4 line error first", id_byte, 'hC6);
    line_err = 0; tick(); chk("R9 timeout next", id_byte, 'hCC);
    rd(); chk("R9 read clears timeout", id_byte, 'hC4);
    rx_level = 0; tick(); chk("R4 transmit next", id_byte, 'hC2);
    rd(); chk("R10 modem next", id_byte, 'hC0);
    chk("R2 pending low bit", irq, 1);
    modem_chg = 0; tick(); chk("R10 xoff next", id_byte, 'hD0);
    rd(); chk("R10 flow next", id_byte, 'hE0);
    rd(); chk("R10 all cleared", id_byte, 'hC1);

    rx_level = 5; rx_tmo = 1; tick(); rx_tmo = 0;
    chk("R9 timeout latched", id_byte, 'hCC);
    rx_level = 0; tick(); chk("R9 cleared by empty", id_byte, 'hC1);

    wr(3, 8'hFF); chk("R11 select 3 ignored", id_byte, 'hC1);
    chk("R11 select 3 dma", dma_sel, 0);

    wr(1, 8'h08);
    chk("R3 mirror off", id_byte, 'h01);
    chk("R11 dma set", dma_sel, 1);
    rx_level = 1; tick(); chk("R5 fifo off trigger 1", id_byte, 'h04);
    rx_level = 0; tx_level = 1; tick(); chk("R6 fifo off not empty", id_byte, 'h01);
    tx_level = 0; tick(); chk("R6 fifo off empty", id_byte, 'h02);

    for (int i = 0; i < 4000; i++) begin
      rx_level = LW'($urandom_range(0, DEPTH));
      tx_level = LW'($urandom_range(0, DEPTH));
      tx_shift_empty = ($urandom_range(0, 3) != 0);
      line_err  = ($urandom_range(0, 7) == 0);
      modem_chg = ($urandom_range(0, 5) == 0);
      rx_tmo    = ($urandom_range(0, 9) == 0);
      xoff_det  = ($urandom_range(0, 9) == 0);
      flow_chg  = ($urandom_range(0, 9) == 0);
      id_rd     = ($urandom_range(0, 2) == 0);
      thr_we    = ($urandom_range(0, 5) == 0);
      cfg_we    = ($urandom_range(0, 7) == 0);
      cfg_sel   = 2'($urandom_range(0, 3));
      cfg_wdata = 8'($urandom_range(0, 255));
      tick();
    end
    cfg_we = 0; id_rd = 0; thr_we = 0; rx_tmo = 0; xoff_det = 0; flow_chg = 0;
    tick();
    finish_run();
  end
endmodule